// File: doc/BRIEF.md
# Flash Completion Poll Controller

This block sits on the host side of a parallel flash device and works out whether a program or erase that software has already started has finished, and whether it finished cleanly. A single start pulse hands it the address to watch, the datum that was written, and whether the operation was an erase. The block then reads that address over a simple synchronous read port, one read outstanding at a time. In each status byte it looks at the completion bit (bit 7) and the time-limit bit (bit 5). Sending the command sequence that starts the operation is not part of this block.

While the operation runs, the device returns the inverse of the written value on bit 7. When bit 7 matches the expected value, the remaining bits are not yet trusted, because they may settle a little later than bit 7. The controller therefore makes one further read and presents that whole byte as the verified data. If the time-limit bit is set while bit 7 still mismatches, bit 7 may have flipped together with it, so one extra read decides between pass and fail. A poll budget set by a parameter ends a stuck wait with a fail.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While reset is applied and after it, `done_o`, `rd_req_o`, `pass_o` and `data_o` are all 0. A reset in the middle of a poll sequence abandons it at once.
- R2: Every read is a one-cycle `rd_req_o` pulse with `rd_addr_o` equal to the address captured at start. The next request is issued only after `rd_valid_i` has returned the previous byte.
- R3: During polling, a status byte whose bit 7 equals the expected bit 7 causes exactly one more read. That read's full byte appears on `data_o`, with `pass_o`=1.
- R4: During polling, a byte whose bit 7 mismatches and whose bit 5 is 0 causes another poll read of the same address.
- R5: During polling, a byte whose bit 7 mismatches and whose bit 5 is 1 causes one recheck read. A bit 7 match there leads to the verify read of R3. A mismatch ends with `pass_o`=0 and the recheck byte on `data_o`.
- R6: With `erase_i`=1 at start, the expected bit 7 is 1 whatever `expect_i` holds. With `erase_i`=0 it is `expect_i[7]`.
- R7: At most MAX_POLLS poll reads are made. If the MAX_POLLS-th poll byte has a bit 7 mismatch and bit 5 = 0, the sequence ends with `pass_o`=0 and that byte on `data_o`. A match or a set bit 5 on that last poll is still handled as in R3 and R5.
- R8: `done_o` is a single-cycle pulse. `pass_o` and `data_o` are valid with it and hold until the next start is accepted. A new start clears `pass_o`.
- R9: `start_i` is ignored from the cycle a start is accepted until the cycle after `done_o`. The captured address, expected bit and mode do not change during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse; captures address, datum and mode when idle |
| erase_i | input | 1 | 1: the operation was an erase (expected bit 7 is 1) |
| addr_i | input | ADDR_W | Address to poll |
| expect_i | input | 8 | Datum that was programmed |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_valid_i | input | 1 | Read data valid, one pulse per request |
| rd_data_i | input | 8 | Read data byte |
| done_o | output | 1 | Completion pulse |
| pass_o | output | 1 | 1: operation verified; 0: failed or timed out |
| data_o | output | 8 | Last byte read (the verified datum on pass) |

## Verification
The checker assumes the read port returns exactly one `rd_valid_i` pulse for each request, and none while no request is pending. The bench's responder model follows that rule: it delays each request through a short pipe and answers once, with a latency of one to three cycles chosen per vector. The checker also assumes `start_i` may arrive at any time. The bench deliberately pulses it mid-sequence with a different address and mode to exercise that assumption.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  localparam int BYTE_W    = 8;
  localparam int BIT_DONE  = 7;  // completion / inverted-datum bit
  localparam int BIT_LIMIT = 5;  // time-limit-exceeded bit

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } state_e;

  typedef enum logic [1:0] {
    PH_POLL    = 2'd0,
    PH_RECHECK = 2'd1,
    PH_VERIFY  = 2'd2
  } phase_e;

endpackage

// File: rtl/fpc_rst_sync.sv
module fpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/fpc_status_eval.sv
module fpc_status_eval
  import flash_poll_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              exp_bit_i,
  output logic              match_o,
  output logic              limit_o
);

  always_comb begin
    match_o = (byte_i[BIT_DONE] == exp_bit_i);
    limit_o = byte_i[BIT_LIMIT];
  end

endmodule

// File: rtl/fpc_poll_counter.sv
module fpc_poll_counter #(
  parameter int MAX_POLLS = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int CW = $clog2(MAX_POLLS) + 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q == LAST_VAL);

endmodule

// File: rtl/fpc_fsm.sv
module fpc_fsm
  import flash_poll_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rd_valid_i,
  input  logic match_i,
  input  logic limit_i,
  input  logic last_poll_i,
  output logic accept_o,
  output logic issue_o,
  output logic capture_o,
  output logic cnt_clr_o,
  output logic cnt_inc_o,
  output logic result_we_o,
  output logic result_pass_o,
  output logic done_o,
  output logic busy_o
);

  state_e state_q, state_d;
  phase_e phase_q, phase_d;

  always_comb begin
    state_d       = state_q;
    phase_d       = phase_q;
    accept_o      = 1'b0;
    capture_o     = 1'b0;
    cnt_clr_o     = 1'b0;
    cnt_inc_o     = 1'b0;
    result_we_o   = 1'b0;
    result_pass_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o  = 1'b1;
          cnt_clr_o = 1'b1;
          phase_d   = PH_POLL;
          state_d   = ST_ISSUE;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (rd_valid_i) begin
          capture_o = 1'b1;
          unique case (phase_q)
            PH_POLL: begin
              cnt_inc_o = 1'b1;
              if (match_i) begin
                phase_d = PH_VERIFY;
                state_d = ST_ISSUE;
              end else if (limit_i) begin
                phase_d = PH_RECHECK;
                state_d = ST_ISSUE;
              end else if (last_poll_i) begin
                result_we_o = 1'b1;
                state_d     = ST_DONE;
              end else begin
                state_d = ST_ISSUE;
              end
            end
            PH_RECHECK: begin
              if (match_i) begin
                phase_d = PH_VERIFY;
                state_d = ST_ISSUE;
              end else begin
                result_we_o = 1'b1;
                state_d     = ST_DONE;
              end
            end
            default: begin
              result_we_o   = 1'b1;
              result_pass_o = 1'b1;
              state_d       = ST_DONE;
            end
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_POLL;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

  assign issue_o = (state_q == ST_ISSUE);
  assign done_o  = (state_q == ST_DONE);
  assign busy_o  = (state_q != ST_IDLE);

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int MAX_POLLS = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] expect_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [BYTE_W-1:0] data_o
);

  logic              rst_n;
  logic              accept, capture, cnt_clr, cnt_inc;
  logic              result_we, result_pass, last_poll;
  logic              match, limit, busy;
  logic [ADDR_W-1:0] addr_q;
  logic              exp_bit_q;
  logic              pass_q;
  logic [BYTE_W-1:0] data_q;

  fpc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  fpc_status_eval u_eval (
    .byte_i    (rd_data_i),
    .exp_bit_i (exp_bit_q),
    .match_o   (match),
    .limit_o   (limit)
  );

  fpc_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .last_o (last_poll)
  );

  fpc_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .start_i       (start_i),
    .rd_valid_i    (rd_valid_i),
    .match_i       (match),
    .limit_i       (limit),
    .last_poll_i   (last_poll),
    .accept_o      (accept),
    .issue_o       (rd_req_o),
    .capture_o     (capture),
    .cnt_clr_o     (cnt_clr),
    .cnt_inc_o     (cnt_inc),
    .result_we_o   (result_we),
    .result_pass_o (result_pass),
    .done_o        (done_o),
    .busy_o        (busy)
  );

  // Request context, loaded only when a start is accepted.
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      exp_bit_q <= 1'b0;
    end else if (accept) begin
      addr_q    <= addr_i;
      exp_bit_q <= erase_i | expect_i[BIT_DONE];
    end
  end

  // Result flag: cleared on accept, written when the sequence ends.
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
    end else if (accept | result_we) begin
      pass_q <= result_we & result_pass;
    end
  end

  // Last byte returned by the read port.
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (capture) begin
      data_q <= rd_data_i;
    end
  end

  assign rd_addr_o = addr_q;
  assign pass_o    = pass_q;
  assign data_o    = data_q;

endmodule

// File: rtl/flash_poll_ctrl_chk.sv
module flash_poll_ctrl_chk #(
  parameter int ADDR_W    = 21,
  parameter int MAX_POLLS = 4096
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_i,
  input logic              done_o,
  input logic              pass_o,
  input logic [7:0]        data_o,
  input logic              busy
);

  localparam int RW = $clog2(MAX_POLLS + 3) + 1;

  logic [RW-1:0] req_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_cnt_q <= '0;
    end else if (start_i && !busy) begin
      req_cnt_q <= '0;
    end else if (rd_req_o) begin
      req_cnt_q <= req_cnt_q + 1'b1;
    end
  end

  // R2: requests are single-cycle pulses
  assert_req_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  // R2: no request while idle
  assert_no_idle_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !rd_req_o);

  // R3: a sequence can only end right after a returned byte
  assert_done_after_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rd_valid_i));

  // R7: total reads bounded by the poll budget plus recheck and verify
  assert_read_budget_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_cnt_q <= RW'(MAX_POLLS + 2));

  // R8: done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8: result held while idle with no start
  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> ($stable(pass_o) && $stable(data_o)));

  // R9: captured address does not move during a sequence
  assert_addr_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(rd_addr_o));

endmodule

bind flash_poll_ctrl flash_poll_ctrl_chk #(.ADDR_W(ADDR_W), .MAX_POLLS(MAX_POLLS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .rd_valid_i (rd_valid_i),
  .done_o     (done_o),
  .pass_o     (pass_o),
  .data_o     (data_o),
  .busy       (busy)
);

// File: tb/flash_poll_ctrl_test.sv
`timescale 1ns/1ps
module flash_poll_ctrl_test;

  localparam int AW  = 21;
  localparam int MAX = 4;

  typedef struct packed {
    logic            erase;
    logic [7:0]      exp;
    logic [1:0]      lat;
    logic [0:5][7:0] resp;
    logic            pass;
    logic [3:0]      reads;
    logic [7:0]      data;
    logic [3:0]      req;
  } vec_t;

  localparam vec_t VECS [9] = '{
    // R3: first poll matches, verify byte returned
    '{1'b0, 8'hA5, 2'd0, {8'hA5, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h00}, 1'b1, 4'd2, 8'hA5, 4'd3},
    // R4: two busy polls, then match; data from verify read
    '{1'b0, 8'h3C, 2'd1, {8'hC3, 8'hC3, 8'h0C, 8'h3C, 8'h00, 8'h00}, 1'b1, 4'd4, 8'h3C, 4'd4},
    // R5: limit bit seen, recheck matches
    '{1'b0, 8'h81, 2'd0, {8'h20, 8'h81, 8'h81, 8'h00, 8'h00, 8'h00}, 1'b1, 4'd3, 8'h81, 4'd5},
    // R5: limit bit seen, recheck mismatches -> fail
    '{1'b0, 8'h81, 2'd2, {8'h20, 8'h24, 8'h00, 8'h00, 8'h00, 8'h00}, 1'b0, 4'd2, 8'h24, 4'd5},
    // R7: budget exhausted -> fail
    '{1'b0, 8'h81, 2'd0, {8'h01, 8'h01, 8'h01, 8'h01, 8'h81, 8'h81}, 1'b0, 4'd4, 8'h01, 4'd7},
    // R6: erase, expected bit 7 forced to 1
    '{1'b1, 8'h00, 2'd1, {8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00}, 1'b1, 4'd3, 8'hFF, 4'd6},
    // R6: erase passes on bit7=1 although expect_i[7]=0
    '{1'b1, 8'h00, 2'd0, {8'h80, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00}, 1'b1, 4'd2, 8'hFF, 4'd6},
    // R7: match on the last allowed poll still passes
    '{1'b0, 8'h81, 2'd0, {8'h01, 8'h01, 8'h01, 8'h81, 8'h81, 8'h00}, 1'b1, 4'd5, 8'h81, 4'd7},
    // R7: limit bit on the last poll still rechecks
    '{1'b0, 8'h81, 2'd1, {8'h01, 8'h01, 8'h01, 8'h21, 8'h81, 8'h7E}, 1'b1, 4'd6, 8'h7E, 4'd7}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, erase_i;
  logic [AW-1:0] addr_i;
  logic [7:0]    expect_i;
  logic          rd_req_o, rd_valid_i, done_o, pass_o;
  logic [AW-1:0] rd_addr_o;
  logic [7:0]    rd_data_i, data_o;

  int errors = 0;
  int checks = 0;

  logic [0:5][7:0] cur_resp;
  logic [1:0]      cur_lat;
  logic [AW-1:0]   cur_addr;
  logic [2:0]      pipe;
  int              idx, nreq, port_err;
  logic            prev_req;

  always #4 clk = ~clk;

  flash_poll_ctrl #(.ADDR_W(AW), .MAX_POLLS(MAX)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start_i),
    .erase_i    (erase_i),
    .addr_i     (addr_i),
    .expect_i   (expect_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .data_o     (data_o)
  );

  // Read-port model: answers each request once, after cur_lat extra cycles.
  always @(negedge clk) begin
    if (!rst_n) begin
      pipe       = '0;
      rd_valid_i = 1'b0;
      rd_data_i  = '0;
      prev_req   = 1'b0;
    end else begin
      rd_valid_i = pipe[cur_lat];
      if (pipe[cur_lat]) begin
        rd_data_i = cur_resp[idx];
        if (idx < 5) idx = idx + 1;
      end
      if (rd_req_o) begin
        nreq = nreq + 1;
        if (rd_addr_o != cur_addr || prev_req) port_err = port_err + 1;
      end
      prev_req = rd_req_o;
      pipe     = {pipe[1:0], rd_req_o};
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    int c = 0;
    while (!done_o && c < 300) begin
      @(negedge clk);
      c++;
    end
    seen = done_o;
    if (!seen) check(1'b0, "R3", "watchdog done", 32'd0, 32'd1);
  endtask

  task automatic launch(input logic er, input logic [7:0] ex, input logic [AW-1:0] ad);
    @(negedge clk);
    idx      = 0;
    nreq     = 0;
    port_err = 0;
    cur_addr = ad;
    start_i  = 1'b1;
    erase_i  = er;
    expect_i = ex;
    addr_i   = ad;
    @(negedge clk);
    start_i  = 1'b0;
  endtask

  initial begin
    bit seen;
    rst_n    = 1'b0;
    start_i  = 1'b0;
    erase_i  = 1'b0;
    addr_i   = '0;
    expect_i = '0;
    cur_resp = '0;
    cur_lat  = '0;
    cur_addr = '0;
    idx = 0; nreq = 0; port_err = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done_o && !rd_req_o && !pass_o && data_o == 8'h00, "R1", "reset outputs",
          {done_o, rd_req_o, pass_o, data_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!done_o && !rd_req_o, "R1", "idle after release", {done_o, rd_req_o}, 32'd0);

    for (int n = 0; n < 9; n++) begin
      cur_resp = VECS[n].resp;
      cur_lat  = VECS[n].lat;
      launch(VECS[n].erase, VECS[n].exp, AW'(21'h1000 + n));
      wait_done(seen);
      check(pass_o == VECS[n].pass, $sformatf("R%0d", VECS[n].req), $sformatf("vec%0d pass", n),
            pass_o, VECS[n].pass);
      check(data_o == VECS[n].data, $sformatf("R%0d", VECS[n].req), $sformatf("vec%0d data", n),
            data_o, VECS[n].data);
      check(nreq == VECS[n].reads, $sformatf("R%0d", VECS[n].req), $sformatf("vec%0d reads", n),
            nreq, VECS[n].reads);
      check(port_err == 0, "R2", $sformatf("vec%0d request addr/pulse", n), port_err, 0);
      @(negedge clk);
      check(!done_o, "R8", $sformatf("vec%0d done width", n), done_o, 0);
    end

    // R8: result holds while idle
    repeat (5) @(negedge clk);
    check(pass_o == 1'b1 && data_o == 8'h7E, "R8", "hold after done", {pass_o, data_o}, {1'b1, 8'h7E});

    // R9: start during a sequence is ignored
    cur_resp = {8'h80, 8'h80, 8'h00, 8'h05, 8'h00, 8'h00};
    cur_lat  = 2'd1;
    launch(1'b0, 8'h00, AW'(21'h0ABC));
    check(pass_o == 1'b0, "R8", "pass cleared on start", pass_o, 0);
    @(negedge clk);
    start_i  = 1'b1;
    erase_i  = 1'b1;
    addr_i   = AW'(21'h1F00F);
    expect_i = 8'hFF;
    @(negedge clk);
    start_i  = 1'b0;
    wait_done(seen);
    check(pass_o && data_o == 8'h05, "R9", "result unaffected", {pass_o, data_o}, {1'b1, 8'h05});
    check(nreq == 4, "R9", "read count unaffected", nreq, 4);
    check(port_err == 0, "R9", "address unchanged", port_err, 0);

    // R1: reset in the middle of a sequence
    cur_resp = {8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01};
    cur_lat  = 2'd2;
    launch(1'b0, 8'h81, AW'(21'h0077));
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!done_o && !rd_req_o && !pass_o && data_o == 8'h00, "R1", "mid-run reset",
          {done_o, rd_req_o, pass_o, data_o}, 32'd0);
    rst_n = 1'b1;
    nreq = 0;
    repeat (12) @(negedge clk);
    check(nreq == 0 && !done_o, "R1", "sequence abandoned", nreq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL R3 global watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule